// File: doc/BRIEF.md
# DMA Interrupt Status and Enable Registers

This block holds the interrupt status word of a packet DMA engine, together with a matching interrupt-enable word, behind a simple single-cycle register bus. Single-cycle event pulses from the transmit and receive DMA paths set sticky flags, and software clears a flag by writing a 1 to its position in the status word. The same status word also carries four other kinds of field. A 3-bit record of the last fatal bus error is captured when that error is first flagged. Two 3-bit fields mirror the current state codes of the transmit and receive state machines. Three bits follow level-type requests from an external timestamp unit, a power-management unit and a statistics-counter unit.

Each sticky flag and each external level bit has an enable bit at the same position in the enable word. The single interrupt output is a registered OR of every enabled bit. Read data is combinational from the bus address. Status is at byte offset 0x0, enable is at offset 0x4, and every other address reads as zero.

Top module: `dma_irq_status`

## Requirements
- R1: A 1 on bit k of `evt_pulse` (k from 0 to 16) sets status bit k at the next clock edge, and the bit stays set until software clears it.
- R2: A bus write to offset 0x0 clears every sticky status bit (bits 16..0) whose write-data bit is 1. Bits written with 0 keep their value.
- R3: When an event pulse and a write-1 clear reach the same sticky bit in the same cycle, the bit remains set.
- R4: The enable word at offset 0x4 is readable and writable in bits 16..0 and 29..27, and reads 0 in all other bits. Unmapped addresses read 0.
- R5: Status bits 25..23 are loaded in the same cycle that the fatal-bus-error flag (bit 13) goes from clear to set. Bit 23 is 1 for a transmit-path error and 0 for receive. Bit 24 is 1 for a read and 0 for a write. Bit 25 is 1 for a descriptor access and 0 for a data-buffer access. The field holds its value while bit 13 stays set, ignores later errors during that time, and reads 0 while bit 13 is clear.
- R6: Status bits 22..20 show `tx_fsm` and bits 19..17 show `rx_fsm` in the same cycle. A bus write does not change them.
- R7: Status bits 29, 28 and 27 show `ts_lvl`, `pm_lvl` and `cnt_lvl` respectively. A bus write of 1 to these bits does not clear them.
- R8: Status bits 31, 30 and 26 always read 0.
- R9: After each clock edge, `irq` equals the OR, taken at that edge, of every sticky flag and every level bit whose enable bit is set.
- R10: After reset, the sticky flags, the enable word, the error field and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (4) | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_pulse | input | NUM_EVT (17) | Sticky event set pulses |
| err_is_tx | input | 1 | Error came from the transmit path |
| err_is_rd | input | 1 | Error occurred on a read transfer |
| err_is_desc | input | 1 | Error occurred on a descriptor access |
| tx_fsm | input | 3 | Transmit state-machine code |
| rx_fsm | input | 3 | Receive state-machine code |
| ts_lvl | input | 1 | Timestamp unit request level |
| pm_lvl | input | 1 | Power-management request level |
| cnt_lvl | input | 1 | Statistics-counter request level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a second fatal error that arrives while the first is still flagged. The hardest variant of it is a new fatal error pulse in the same cycle as software's write-1 clear of bit 13: the flag must stay set, and the error field must keep the first error's details. Directed stimulus first latches one error pattern. It then pulses bit 13 again with a different pattern, and then combines that pulse with a clearing write. A random phase with sparse event pulses and random writes follows. A behavioural model in the bench tracks every field on every clock.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int DATA_W    = 32;
   localparam int FATAL_BIT = 13;
   localparam int RX_LSB    = 17;
   localparam int TX_LSB    = 20;
   localparam int ERR_LSB   = 23;
   localparam int LVL_LSB   = 27;
   localparam int CODE_W    = 3;
endpackage

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
   import dma_irq_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int STAT_OFS = 0,
   parameter int EN_OFS   = 4
) (
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] stat_word,
   input  logic [DATA_W-1:0] en_word,
   output logic              stat_we,
   output logic              en_we,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

   assign stat_we = reg_sel && reg_wr && (reg_addr == STAT_A);
   assign en_we   = reg_sel && reg_wr && (reg_addr == EN_A);

   always_comb begin
      if (reg_addr == STAT_A)    rdata = stat_word;
      else if (reg_addr == EN_A) rdata = en_word;
      else                       rdata = '0;
   end
endmodule

// File: rtl/dma_irq_sticky.sv
module dma_irq_sticky #(
   parameter int N = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_o[i] <= 1'b0;
         else if (set_i[i])   flag_o[i] <= 1'b1;
         else if (clr_i[i])   flag_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_irq_errcap.sv
module dma_irq_errcap
   import dma_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic              flag_q,
   input  logic [CODE_W-1:0] det_i,
   output logic [CODE_W-1:0] err_o
);
   logic flag_nx;
   assign flag_nx = set_i | (flag_q & ~clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        err_o <= '0;
      else if (!flag_nx) err_o <= '0;
      else if (!flag_q)  err_o <= det_i;
   end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dma_irq_pkg::*;
#(
   parameter int NUM_EVT  = 17,
   parameter int ADDR_W   = 4,
   parameter int STAT_OFS = 0,
   parameter int EN_OFS   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   input  logic               err_is_tx,
   input  logic               err_is_rd,
   input  logic               err_is_desc,
   input  logic [2:0]         tx_fsm,
   input  logic [2:0]         rx_fsm,
   input  logic               ts_lvl,
   input  logic               pm_lvl,
   input  logic               cnt_lvl,
   output logic               irq
);
   localparam logic [DATA_W-1:0] EVT_MASK = DATA_W'((64'd1 << NUM_EVT) - 64'd1);
   localparam logic [DATA_W-1:0] EN_MASK  = EVT_MASK | (DATA_W'(7) << LVL_LSB);

   if (NUM_EVT <= FATAL_BIT || NUM_EVT > RX_LSB) begin : g_bad_evt
      $error("NUM_EVT must cover the fatal bit and stay below the rx state field");
   end
   if (STAT_OFS == EN_OFS || (STAT_OFS % 4) != 0 || (EN_OFS % 4) != 0) begin : g_bad_ofs
      $error("register offsets must be distinct and word aligned");
   end
   if (ADDR_W < 3 || (1 << ADDR_W) <= STAT_OFS || (1 << ADDR_W) <= EN_OFS) begin : g_bad_aw
      $error("ADDR_W too narrow for the register offsets");
   end

   logic               stat_we, en_we;
   logic [NUM_EVT-1:0] flags, clr_m;
   logic [DATA_W-1:0]  en_q, stat_word;
   logic [CODE_W-1:0]  err_q;
   logic [2:0]         lvl;

   assign lvl   = {ts_lvl, pm_lvl, cnt_lvl};
   assign clr_m = stat_we ? reg_wdata[NUM_EVT-1:0] : '0;

   dma_irq_regif #(
      .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)
   ) u_regif (
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .stat_word(stat_word), .en_word(en_q),
      .stat_we(stat_we), .en_we(en_we), .rdata(reg_rdata)
   );

   dma_irq_sticky #(.N(NUM_EVT)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(evt_pulse), .clr_i(clr_m), .flag_o(flags)
   );

   dma_irq_errcap u_errcap (
      .clk(clk), .rst_n(rst_n),
      .set_i(evt_pulse[FATAL_BIT]), .clr_i(clr_m[FATAL_BIT]),
      .flag_q(flags[FATAL_BIT]),
      .det_i({err_is_desc, err_is_rd, err_is_tx}),
      .err_o(err_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= reg_wdata & EN_MASK;
   end

   always_comb begin
      stat_word                             = '0;
      stat_word[NUM_EVT-1:0]                = flags;
      stat_word[RX_LSB +: CODE_W]           = rx_fsm;
      stat_word[TX_LSB +: CODE_W]           = tx_fsm;
      stat_word[ERR_LSB +: CODE_W]          = err_q;
      stat_word[LVL_LSB +: 3]               = lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (|(flags & en_q[NUM_EVT-1:0])) | (|(lvl & en_q[LVL_LSB +: 3]));
   end
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_EVT  = 17,
   parameter int ADDR_W   = 4,
   parameter int STAT_OFS = 0,
   parameter int EN_OFS   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_sel,
   input logic               reg_wr,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [NUM_EVT-1:0] evt_pulse,
   input logic [NUM_EVT-1:0] flags,
   input logic [31:0]        en_q,
   input logic [2:0]         err_q,
   input logic               ts_lvl,
   input logic               pm_lvl,
   input logic               cnt_lvl,
   input logic               irq
);
   localparam logic [31:0] EN_OK = 32'((64'd1 << NUM_EVT) - 64'd1) | (32'd7 << LVL_LSB);

   logic               wr_stat;
   logic [NUM_EVT-1:0] wclr;
   logic               want_irq;
   assign wr_stat  = reg_sel && reg_wr && (reg_addr == ADDR_W'(STAT_OFS));
   assign wclr     = wr_stat ? reg_wdata[NUM_EVT-1:0] : '0;
   assign want_irq = (|(flags & en_q[NUM_EVT-1:0])) |
                     (ts_lvl & en_q[LVL_LSB+2]) | (pm_lvl & en_q[LVL_LSB+1]) |
                     (cnt_lvl & en_q[LVL_LSB]);

   // R1 R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> (($past(evt_pulse) & ~flags) == '0));

   // R2
   zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flags) & ~$past(wclr)) & ~flags) == '0));

   // R2
   one_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> ((flags & $past(wclr & ~evt_pulse)) == '0));

   // R4
   en_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q & ~EN_OK) == '0);

   // R5
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[FATAL_BIT] |=> (!flags[FATAL_BIT] || $stable(err_q)));

   // R5
   err_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[FATAL_BIT] |-> (err_q == '0));

   // R9
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(want_irq)));
endmodule

bind dma_irq_status dma_irq_status_chk #(
   .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .EN_OFS(EN_OFS)
) u_chk (.*);

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [16:0] evt_pulse = '0;
   logic        err_is_tx = 1'b0, err_is_rd = 1'b0, err_is_desc = 1'b0;
   logic [2:0]  tx_fsm = '0, rx_fsm = '0;
   logic        ts_lvl = 1'b0, pm_lvl = 1'b0, cnt_lvl = 1'b0;
   logic        irq;

   always #5 clk = ~clk;

   dma_irq_status uut (.*);

   int checks = 0, fails = 0;
   bit done = 0;

   logic [16:0] m_s = '0;
   logic [31:0] m_en = '0;
   logic [2:0]  m_err = '0;
   logic        m_irq = 1'b0;
   localparam logic [31:0] EN_OK = 32'h3800_0000 | 32'h0001_FFFF;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: drive at negedge, compare, advance model at posedge
   task automatic step(input string tag, input logic sel, input logic wr,
                       input logic [3:0] addr, input logic [31:0] wd,
                       input logic [16:0] ev, input logic [2:0] einfo,
                       input logic [2:0] tx, input logic [2:0] rx, input logic [2:0] lv);
      logic [16:0] clr, s_n;
      logic [2:0]  e_n;
      logic        i_n;
      @(negedge clk);
      reg_sel = sel; reg_wr = wr; reg_addr = addr; reg_wdata = wd; evt_pulse = ev;
      {err_is_desc, err_is_rd, err_is_tx} = einfo;
      tx_fsm = tx; rx_fsm = rx; {ts_lvl, pm_lvl, cnt_lvl} = lv;
      #1;
      if (addr == 4'h0) begin
         chk({tag, " sticky"}, {15'd0, reg_rdata[16:0]}, {15'd0, m_s});
         chk("R5 error field", {29'd0, reg_rdata[25:23]}, {29'd0, (m_s[13] ? m_err : 3'b000)});
         chk("R6 tx state", {29'd0, reg_rdata[22:20]}, {29'd0, tx});
         chk("R6 rx state", {29'd0, reg_rdata[19:17]}, {29'd0, rx});
         chk("R7 levels", {29'd0, reg_rdata[29:27]}, {29'd0, lv});
         chk("R8 reserved", {29'd0, reg_rdata[31:30], reg_rdata[26]}, 32'd0);
      end else if (addr == 4'h4) begin
         chk({tag, " enable"}, reg_rdata, m_en);
      end else begin
         chk("R4 unmapped", reg_rdata, 32'd0);
      end
      chk({tag, " irq R9"}, {31'd0, irq}, {31'd0, m_irq});
      clr = (sel && wr && addr == 4'h0) ? wd[16:0] : 17'd0;
      s_n = (m_s & ~clr) | ev;
      if (!m_s[13] && ev[13]) e_n = einfo;
      else if (!s_n[13])      e_n = 3'b000;
      else                    e_n = m_err;
      i_n = (|(m_s & m_en[16:0])) | (|(lv & m_en[29:27]));
      @(posedge clk);
      m_s = s_n; m_err = e_n; m_irq = i_n;
      if (sel && wr && addr == 4'h4) m_en = wd & EN_OK;
   endtask

   task automatic idle(input string tag, input logic [3:0] addr, input logic [2:0] lv);
      step(tag, 1'b1, 1'b0, addr, 32'd0, 17'd0, 3'd0, 3'd2, 3'd5, lv);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R10 reset state
      idle("R10", 4'h0, 3'd0);
      idle("R10", 4'h4, 3'd0);
      // R1 set by pulses
      step("R1", 1'b0, 1'b0, 4'h0, 32'd0, 17'h10021, 3'd0, 3'd1, 3'd0, 3'd0);
      idle("R1", 4'h0, 3'd0);
      idle("R1", 4'h0, 3'd0);
      // R2 write-1 clears bit 5, write-0 keeps others
      step("R2", 1'b1, 1'b1, 4'h0, 32'h0000_0020, 17'd0, 3'd0, 3'd3, 3'd0, 3'd0);
      idle("R2", 4'h0, 3'd0);
      step("R2", 1'b1, 1'b1, 4'h0, 32'h0000_0000, 17'd0, 3'd0, 3'd6, 3'd0, 3'd0);
      idle("R2", 4'h0, 3'd0);
      // R4 enable register, reserved bits masked
      step("R4", 1'b1, 1'b1, 4'h4, 32'hFFFF_FFFF, 17'd0, 3'd0, 3'd7, 3'd0, 3'd0);
      idle("R4", 4'h4, 3'd0);
      idle("R9", 4'h8, 3'd0);
      // R3 collision of set and clear on bit 0
      step("R3", 1'b1, 1'b1, 4'h0, 32'h0001_0001, 17'h00001, 3'd0, 3'd0, 3'd0, 3'd0);
      idle("R3", 4'h0, 3'd0);
      step("R9", 1'b1, 1'b1, 4'h0, 32'h0001_FFFF, 17'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      idle("R9", 4'h0, 3'd0);
      idle("R9", 4'h0, 3'd0);
      // R5 first fatal error latched, later ones ignored while set
      step("R5", 1'b0, 1'b0, 4'h0, 32'd0, 17'h02000, 3'b101, 3'd0, 3'd0, 3'd0);
      idle("R5", 4'h0, 3'd0);
      step("R5", 1'b0, 1'b0, 4'h0, 32'd0, 17'h02000, 3'b010, 3'd0, 3'd0, 3'd0);
      idle("R5", 4'h0, 3'd0);
      step("R5", 1'b1, 1'b1, 4'h0, 32'h0000_2000, 17'h02000, 3'b011, 3'd0, 3'd0, 3'd0);
      idle("R5", 4'h0, 3'd0);
      step("R5", 1'b1, 1'b1, 4'h0, 32'h0000_2000, 17'd0, 3'b000, 3'd0, 3'd0, 3'd0);
      idle("R5", 4'h0, 3'd0);
      step("R5", 1'b0, 1'b0, 4'h0, 32'd0, 17'h02000, 3'b011, 3'd0, 3'd0, 3'd0);
      idle("R5", 4'h0, 3'd0);
      // R7 levels pass through and survive write-1
      idle("R7", 4'h0, 3'b101);
      step("R7", 1'b1, 1'b1, 4'h0, 32'h3BF0_2000, 17'd0, 3'd0, 3'd4, 3'd6, 3'b101);
      idle("R7", 4'h0, 3'b101);
      idle("R7", 4'h0, 3'b010);
      step("R7", 1'b1, 1'b1, 4'h4, 32'h1000_0000, 17'd0, 3'd0, 3'd0, 3'd0, 3'b010);
      idle("R7", 4'h0, 3'b010);
      idle("R7", 4'h0, 3'b000);
      idle("R7", 4'h0, 3'b000);
      // R6 mirrors not writable
      step("R6", 1'b1, 1'b1, 4'h0, 32'h00FE_0000, 17'd0, 3'd0, 3'd1, 3'd3, 3'd0);
      idle("R6", 4'h0, 3'd0);
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [31:0] wd;
         logic [3:0]  ad;
         wd = $urandom;
         ad = ($urandom % 3 == 0) ? 4'h4 : (($urandom % 8 == 0) ? 4'hC : 4'h0);
         step("R1", ($urandom % 4) != 0, ($urandom % 3) == 0, ad, wd,
              17'($urandom & $urandom & $urandom), 3'($urandom), 3'($urandom),
              3'($urandom), 3'($urandom & $urandom));
      end
      done = 1;
      summary();
      $finish;
   end
endmodule